// File: doc/BRIEF.md
# Endpoint Test Command Engine

This block is a self-test engine for a bus endpoint. A host drives it through a small register window. Writing a command word either raises one interrupt, or starts a transfer over a simple request/acknowledge memory master port into host-side buffers. A transfer can read a buffer and check its checksum, write a known pattern into a buffer, or copy one buffer to another.

When a command finishes, the engine reports the result as separate success and fail flags for each kind of operation. It has two further flags for a bad source address and a bad destination address. It can also signal completion with an interrupt of a software-selected kind. The interrupt outputs are single-cycle pulses on a legacy line, an MSI line or an MSI-X line. Each pulse comes with a vector number.

A further scratch register lets the host confirm that the register window works at all.

Top module: `ept_engine`

## Requirements
- R1: The scratch register at word offset 2 returns exactly the last value written to it.
- R2: The register word offsets are: 0 command, 1 status, 2 scratch, 3 interrupt kind, 4 interrupt number, 5 source address, 6 destination address, 7 length in 32-bit words, 8 checksum. After reset every register reads zero. A command write while idle sets the command bits and clears status in the same edge. The command bits keep reading back until the operation ends, and then read zero.
- R3: Command bit meanings are: bit0 legacy interrupt, bit1 MSI, bit2 MSI-X, bit3 read, bit4 write, bit5 copy. When several bits are set, only the lowest one is carried out.
- R4: A command write while the command register is nonzero is ignored.
- R5: A raise command gives exactly one single-cycle pulse on the line its bit names. The interrupt vector output equals the interrupt number register during the pulse, and status bit6 is set.
- R6: Interrupt kind codes are 0 legacy, 1 MSI, 2 MSI-X; code 3 raises nothing. Legal numbers are 0 for legacy, 1 to 32 for MSI and 1 to 2048 for MSI-X. A number outside that range gives no pulse and leaves status bit6 clear.
- R7: A read fetches length words from the source address, one by one, at source + 4*i. It XORs them together. If the result equals the checksum register it sets status bit0, and otherwise bit1.
- R8: A write stores the value i at destination + 4*i for i from 0 to length-1. It then places the XOR of those values in the checksum register and sets status bit2. The memory request holds its address until acknowledged.
- R9: A copy moves length words from source + 4*i to destination + 4*i in order and sets status bit4.
- R10: An address that is zero or not a multiple of 4 is invalid. A bad source sets status bit7 and a bad destination sets bit8. Either one sets the operation's fail flag (read bit1, write bit3, copy bit5), and no memory access takes place.
- R11: When a read, write or copy finishes, the engine raises one completion interrupt. Its kind comes from the interrupt kind register and it follows the R6 rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a write request, 0 for a read request |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Acknowledge; read data is valid with it |
| mem_rdata_i | input | 32 | Read data |
| irq_legacy_o | output | 1 | Legacy interrupt pulse |
| irq_msi_o | output | 1 | MSI pulse |
| irq_msix_o | output | 1 | MSI-X pulse |
| irq_vec_o | output | VEC_W | Interrupt number, valid during a pulse |

## Verification
A corrupted word counter or accumulator shows up at the ports on the next acknowledged access. The request address drifts from source + 4*i, or the stored pattern breaks. When the operation ends, the checksum register or the read success flag is wrong. A wrong command decode or priority shows when the command ends, as the wrong status bit or a pulse on the wrong line. An invalid address that slips through shows as a request on the memory port within one cycle of the start. Because of this, the bench sweeps the lengths, the interrupt kinds, the number boundaries, mixed command bits and busy rewrites, and compares the memory image, the checksum, the status, and each pulse and its vector.

// File: rtl/ept_pkg.sv
package ept_pkg;
   localparam int REG_AW = 4;
   localparam int CMD_W  = 6;
   localparam int STAT_W = 9;

   localparam logic [REG_AW-1:0] A_CMD   = 4'd0;
   localparam logic [REG_AW-1:0] A_STAT  = 4'd1;
   localparam logic [REG_AW-1:0] A_MAGIC = 4'd2;
   localparam logic [REG_AW-1:0] A_ITYPE = 4'd3;
   localparam logic [REG_AW-1:0] A_INUM  = 4'd4;
   localparam logic [REG_AW-1:0] A_SRC   = 4'd5;
   localparam logic [REG_AW-1:0] A_DST   = 4'd6;
   localparam logic [REG_AW-1:0] A_LEN   = 4'd7;
   localparam logic [REG_AW-1:0] A_CHK   = 4'd8;

   localparam int S_RD_OK   = 0;
   localparam int S_RD_FAIL = 1;
   localparam int S_WR_OK   = 2;
   localparam int S_WR_FAIL = 3;
   localparam int S_CP_OK   = 4;
   localparam int S_CP_FAIL = 5;
   localparam int S_IRQ     = 6;
   localparam int S_SRC_BAD = 7;
   localparam int S_DST_BAD = 8;

   typedef enum logic [1:0] {K_LEGACY = 2'd0, K_MSI = 2'd1, K_MSIX = 2'd2, K_NONE = 2'd3} irq_kind_e;
   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} xfer_st_e;
   typedef enum logic [1:0] {OP_IRQ, OP_RD, OP_WR, OP_CP} xfer_op_e;

   function automatic logic [STAT_W-1:0] stat_bit(input int b);
      return {{(STAT_W-1){1'b0}}, 1'b1} << b;
   endfunction
endpackage

// File: rtl/ept_irq_gen.sv
module ept_irq_gen #(
   parameter int MSI_MAX  = 32,
   parameter int MSIX_MAX = 2048,
   parameter int VEC_W    = 12,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fire_i,
   input  logic [1:0]       kind_i,
   input  logic [31:0]      num_i,
   output logic             ok_o,
   output logic [2:0]       pulse_o,
   output logic [VEC_W-1:0] vec_o
);
   import ept_pkg::*;

   logic legal;

   always_comb begin
      unique case (irq_kind_e'(kind_i))
         K_LEGACY: legal = (num_i == 32'd0);
         K_MSI:    legal = (num_i >= 32'd1) && (num_i <= 32'(MSI_MAX));
         K_MSIX:   legal = (num_i >= 32'd1) && (num_i <= 32'(MSIX_MAX));
         default:  legal = 1'b0;
      endcase
   end

   assign ok_o = fire_i && legal;

   for (genvar k = 0; k < 3; k++) begin : g_line
      logic hit;
      assign hit = ok_o && (kind_i == 2'(k));
      if (OUT_REG) begin : g_reg
         logic p_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) p_q <= 1'b0;
            else         p_q <= hit;
         end
         assign pulse_o[k] = p_q;
      end else begin : g_comb
         assign pulse_o[k] = hit;
      end
   end

   if (OUT_REG) begin : g_vec_reg
      logic [VEC_W-1:0] v_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) v_q <= '0;
         else         v_q <= ok_o ? num_i[VEC_W-1:0] : '0;
      end
      assign vec_o = v_q;
   end else begin : g_vec_comb
      assign vec_o = ok_o ? num_i[VEC_W-1:0] : '0;
   end
endmodule

// File: rtl/ept_xfer_fsm.sv
module ept_xfer_fsm #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [ept_pkg::CMD_W-1:0]  cmd_i,
   input  logic [ADDR_W-1:0]          src_i,
   input  logic [ADDR_W-1:0]          dst_i,
   input  logic [LEN_W-1:0]           len_i,
   input  logic [31:0]                chk_ref_i,
   input  logic [1:0]                 irq_type_i,
   output logic                       mem_req_o,
   output logic                       mem_we_o,
   output logic [ADDR_W-1:0]          mem_addr_o,
   output logic [31:0]                mem_wdata_o,
   input  logic                       mem_ack_i,
   input  logic [31:0]                mem_rdata_i,
   output logic                       done_o,
   output logic [ept_pkg::STAT_W-1:0] flags_o,
   output logic [1:0]                 irq_kind_o,
   output logic                       chk_we_o,
   output logic [31:0]                chk_o
);
   import ept_pkg::*;

   xfer_st_e          state_q;
   xfer_op_e          op_q;
   irq_kind_e         kind_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [31:0]       acc_q, buf_q;
   logic [STAT_W-1:0] flags_q;

   logic [CMD_W-1:0] lowest;
   logic             last, src_bad, dst_bad, len_zero;
   logic [31:0]      acc_rd, acc_wr;

   function automatic logic addr_bad(input logic [ADDR_W-1:0] a);
      return (a == '0) || (a[1:0] != 2'b00);
   endfunction

   always_comb begin
      lowest   = cmd_i & (~cmd_i + CMD_W'(1));
      last     = (cnt_q == (len_i - LEN_W'(1)));
      len_zero = (len_i == '0);
      src_bad  = addr_bad(src_i);
      dst_bad  = addr_bad(dst_i);
      acc_rd   = acc_q ^ mem_rdata_i;
      acc_wr   = acc_q ^ 32'(cnt_q);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         op_q    <= OP_IRQ;
         kind_q  <= K_NONE;
         cnt_q   <= '0;
         acc_q   <= '0;
         buf_q   <= '0;
         flags_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cmd_i != '0) begin
               cnt_q   <= '0;
               acc_q   <= '0;
               flags_q <= '0;
               kind_q  <= irq_kind_e'(irq_type_i);
               state_q <= ST_FIN;
               if (|lowest[2:0]) begin
                  op_q   <= OP_IRQ;
                  kind_q <= lowest[0] ? K_LEGACY : (lowest[1] ? K_MSI : K_MSIX);
               end else if (lowest[3]) begin
                  op_q <= OP_RD;
                  if (src_bad)       flags_q <= stat_bit(S_RD_FAIL) | stat_bit(S_SRC_BAD);
                  else if (len_zero) flags_q <= stat_bit((chk_ref_i == '0) ? S_RD_OK : S_RD_FAIL);
                  else               state_q <= ST_RD;
               end else if (lowest[4]) begin
                  op_q <= OP_WR;
                  if (dst_bad)       flags_q <= stat_bit(S_WR_FAIL) | stat_bit(S_DST_BAD);
                  else if (len_zero) flags_q <= stat_bit(S_WR_OK);
                  else               state_q <= ST_WR;
               end else begin
                  op_q <= OP_CP;
                  if (src_bad || dst_bad)
                     flags_q <= stat_bit(S_CP_FAIL)
                              | (src_bad ? stat_bit(S_SRC_BAD) : '0)
                              | (dst_bad ? stat_bit(S_DST_BAD) : '0);
                  else if (len_zero) flags_q <= stat_bit(S_CP_OK);
                  else               state_q <= ST_RD;
               end
            end
            ST_RD: if (mem_ack_i) begin
               if (op_q == OP_CP) begin
                  buf_q   <= mem_rdata_i;
                  state_q <= ST_WR;
               end else begin
                  acc_q <= acc_rd;
                  cnt_q <= cnt_q + LEN_W'(1);
                  if (last) begin
                     flags_q <= stat_bit((acc_rd == chk_ref_i) ? S_RD_OK : S_RD_FAIL);
                     state_q <= ST_FIN;
                  end
               end
            end
            ST_WR: if (mem_ack_i) begin
               acc_q <= acc_wr;
               cnt_q <= cnt_q + LEN_W'(1);
               if (last) begin
                  flags_q <= stat_bit((op_q == OP_CP) ? S_CP_OK : S_WR_OK);
                  state_q <= ST_FIN;
               end else if (op_q == OP_CP) begin
                  state_q <= ST_RD;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
   assign mem_we_o    = (state_q == ST_WR);
   assign mem_addr_o  = ((state_q == ST_RD) ? src_i : dst_i) + ADDR_W'({cnt_q, 2'b00});
   assign mem_wdata_o = (op_q == OP_CP) ? buf_q : 32'(cnt_q);
   assign done_o      = (state_q == ST_FIN);
   assign flags_o     = flags_q;
   assign irq_kind_o  = kind_q;
   assign chk_we_o    = done_o && (op_q == OP_WR) && flags_q[S_WR_OK];
   assign chk_o       = acc_q;
endmodule

// File: rtl/ept_engine.sv
module ept_engine #(
   parameter int ADDR_W      = 32,
   parameter int LEN_W       = 16,
   parameter int MSI_MAX     = 32,
   parameter int MSIX_MAX    = 2048,
   parameter int VEC_W       = 12,
   parameter bit IRQ_OUT_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic [3:0]        reg_addr_i,
   input  logic [31:0]       reg_wdata_i,
   output logic [31:0]       reg_rdata_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   output logic              irq_legacy_o,
   output logic              irq_msi_o,
   output logic              irq_msix_o,
   output logic [VEC_W-1:0]  irq_vec_o
);
   import ept_pkg::*;

   if (MSI_MAX < 1 || MSI_MAX > MSIX_MAX) begin : g_bad_msi
      $error("MSI_MAX must lie in 1..MSIX_MAX");
   end
   if (MSIX_MAX >= (1 << VEC_W)) begin : g_bad_vec
      $error("VEC_W too narrow for MSIX_MAX");
   end
   if (ADDR_W < 8 || ADDR_W > 32 || LEN_W < 1 || LEN_W + 2 > ADDR_W) begin : g_bad_width
      $error("ADDR_W/LEN_W out of range");
   end

   logic [31:0]       magic_q, chk_q, inum_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [STAT_W-1:0] status_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [LEN_W-1:0]  len_q;
   logic [1:0]        itype_q;

   logic              done, chk_we, irq_ok;
   logic [STAT_W-1:0] flags;
   logic [1:0]        kind;
   logic [31:0]       chk_new;
   logic [2:0]        pulses;

   ept_xfer_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_xfer (
      .clk_i, .rst_ni,
      .cmd_i(cmd_q), .src_i(src_q), .dst_i(dst_q), .len_i(len_q),
      .chk_ref_i(chk_q), .irq_type_i(itype_q),
      .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
      .done_o(done), .flags_o(flags), .irq_kind_o(kind),
      .chk_we_o(chk_we), .chk_o(chk_new)
   );

   ept_irq_gen #(.MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX), .VEC_W(VEC_W), .OUT_REG(IRQ_OUT_REG)) u_irq (
      .clk_i, .rst_ni,
      .fire_i(done), .kind_i(kind), .num_i(inum_q),
      .ok_o(irq_ok), .pulse_o(pulses), .vec_o(irq_vec_o)
   );

   assign irq_legacy_o = pulses[0];
   assign irq_msi_o    = pulses[1];
   assign irq_msix_o   = pulses[2];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         magic_q  <= '0;
         cmd_q    <= '0;
         status_q <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         len_q    <= '0;
         chk_q    <= '0;
         itype_q  <= '0;
         inum_q   <= '0;
      end else begin
         if (reg_wr_i) begin
            unique case (reg_addr_i)
               A_CMD: if (cmd_q == '0) begin
                  cmd_q    <= reg_wdata_i[CMD_W-1:0];
                  status_q <= '0;
               end
               A_MAGIC: magic_q <= reg_wdata_i;
               A_ITYPE: itype_q <= reg_wdata_i[1:0];
               A_INUM:  inum_q  <= reg_wdata_i;
               A_SRC:   src_q   <= reg_wdata_i[ADDR_W-1:0];
               A_DST:   dst_q   <= reg_wdata_i[ADDR_W-1:0];
               A_LEN:   len_q   <= reg_wdata_i[LEN_W-1:0];
               A_CHK:   chk_q   <= reg_wdata_i;
               default: ;
            endcase
         end
         if (done) begin
            cmd_q           <= '0;
            status_q        <= flags;
            status_q[S_IRQ] <= irq_ok;
         end
         if (chk_we) chk_q <= chk_new;
      end
   end

   always_comb begin
      unique case (reg_addr_i)
         A_CMD:   reg_rdata_o = 32'(cmd_q);
         A_STAT:  reg_rdata_o = 32'(status_q);
         A_MAGIC: reg_rdata_o = magic_q;
         A_ITYPE: reg_rdata_o = 32'(itype_q);
         A_INUM:  reg_rdata_o = inum_q;
         A_SRC:   reg_rdata_o = 32'(src_q);
         A_DST:   reg_rdata_o = 32'(dst_q);
         A_LEN:   reg_rdata_o = 32'(len_q);
         A_CHK:   reg_rdata_o = chk_q;
         default: reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/ept_checker.sv
module ept_checker #(
   parameter int ADDR_W  = 32,
   parameter int MSI_MAX = 32,
   parameter int VEC_W   = 12
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              reg_wr_i,
   input logic [3:0]        reg_addr_i,
   input logic [5:0]        cmd,
   input logic [8:0]        status,
   input logic              mem_req_o,
   input logic              mem_we_o,
   input logic              mem_ack_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              irq_legacy_o,
   input logic              irq_msi_o,
   input logic              irq_msix_o,
   input logic [VEC_W-1:0]  irq_vec_o
);
   logic any_irq;
   assign any_irq = irq_legacy_o | irq_msi_o | irq_msix_o;

   // R5
   irq_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({irq_legacy_o, irq_msi_o, irq_msix_o}));

   // R5
   irq_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_irq |=> !any_irq);

   // R6
   legacy_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_legacy_o |-> (irq_vec_o == '0));

   // R6
   msi_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_msi_o |-> (irq_vec_o >= VEC_W'(1) && irq_vec_o <= VEC_W'(MSI_MAX)));

   // R4
   busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd != '0 && reg_wr_i && reg_addr_i == 4'd0) |=> (cmd == $past(cmd) || cmd == '0));

   // R2
   status_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd == '0 && reg_wr_i && reg_addr_i == 4'd0) |=> (status == '0));

   // R10
   aligned_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00 && mem_addr_o != '0));

   // R8
   req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

bind ept_engine ept_checker #(.ADDR_W(ADDR_W), .MSI_MAX(MSI_MAX), .VEC_W(VEC_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
   .cmd(cmd_q), .status(status_q),
   .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o),
   .irq_legacy_o(irq_legacy_o), .irq_msi_o(irq_msi_o), .irq_msix_o(irq_msix_o), .irq_vec_o(irq_vec_o)
);

// File: tb/ept_engine_tb.sv
module ept_engine_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [3:0] R_CMD = 0, R_STAT = 1, R_MAGIC = 2, R_ITYPE = 3, R_INUM = 4,
                          R_SRC = 5, R_DST = 6, R_LEN = 7, R_CHK = 8;
   localparam logic [31:0] SRC = 32'h40, DST = 32'h80;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        irq_l, irq_m, irq_x;
   logic [11:0] irq_vec;

   int n_cmp = 0, n_mis = 0, n_acc = 0;
   logic [31:0] mem [64];
   logic [1:0]  lat = 2'd0, wcnt = 2'd0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ept_engine dut_i (
      .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
      .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .irq_legacy_o(irq_l), .irq_msi_o(irq_m), .irq_msix_o(irq_x), .irq_vec_o(irq_vec)
   );

   // host memory model with rotating latency
   assign mem_rdata = mem_ack ? mem[mem_addr[7:2]] : '0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; wcnt <= '0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         n_acc   <= n_acc + 1;
         if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            mem_ack <= 1'b1; wcnt <= '0; lat <= (lat == 2'd2) ? 2'd0 : lat + 2'd1;
         end else wcnt <= wcnt + 2'd1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   int pl, pm, px;
   logic [11:0] last_vec;

   task automatic wait_done();
      logic [31:0] c;
      bit fin = 0;
      pl = 0; pm = 0; px = 0; last_vec = '0;
      reg_addr = R_CMD;
      for (int i = 0; i < 3000 && !fin; i++) begin
         @(posedge clk); @(negedge clk);
         if (irq_l) pl++;
         if (irq_m) pm++;
         if (irq_x) px++;
         if (irq_l | irq_m | irq_x) last_vec = irq_vec;
         #1; c = reg_rdata;
         if (c == 0) fin = 1;
      end
      if (!fin) begin
         n_cmp++; n_mis++;
         $display("FAIL R2 command never cleared actual=nonzero expected=0");
      end
      // one more cycle to catch a late pulse
      @(posedge clk); @(negedge clk);
      if (irq_l) pl++;
      if (irq_m) pm++;
      if (irq_x) px++;
   endtask

   task automatic run_cmd(input logic [31:0] c);
      reg_write(R_CMD, c);
      wait_done();
   endtask

   // completion interrupt setting t: 0 legacy/0, 1 MSI/7, 2 MSI-X/1500, 3 none, 4 MSI/40 (out of range)
   function automatic logic [31:0] ityp(input int t);
      return (t == 4) ? 32'd1 : 32'(t);
   endfunction
   function automatic logic [31:0] inum(input int t);
      case (t) 0: return 0; 1: return 7; 2: return 1500; 3: return 1; default: return 40; endcase
   endfunction

   task automatic check_irq(input string req, input int t);
      check(req, pl, (t == 0) ? 1 : 0);
      check(req, pm, (t == 1) ? 1 : 0);
      check(req, px, (t == 2) ? 1 : 0);
      if (t <= 2) check(req, 32'(last_vec), inum(t) & 32'hFFF);
   endtask

   function automatic logic [31:0] pat(input int i, input int n);
      return 32'h1357_0000 + 32'(i) * 32'h0101_0101 + 32'(n);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_mis++; n_cmp++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      logic [31:0] d, x;
      int a0;
      for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset values
      for (int r = 0; r <= 8; r++) begin
         reg_read(4'(r), d); check("R2 reset register", d, 0);
      end
      check("R5 no pulse after reset", {irq_l, irq_m, irq_x}, 0);

      // R1 scratch readback
      for (int b = 0; b < 32; b++) begin
         reg_write(R_MAGIC, 32'h1 << b); reg_read(R_MAGIC, d); check("R1 walking one", d, 32'h1 << b);
      end
      reg_write(R_MAGIC, 32'hA5C3_0FF1); reg_read(R_MAGIC, d); check("R1 pattern", d, 32'hA5C3_0FF1);

      // R5 R6 raise commands across number boundaries
      for (int k = 0; k < 3; k++) begin
         for (int j = 0; j < 8; j++) begin
            logic [31:0] nums [8] = '{0, 1, 2, 32, 33, 2047, 2048, 2049};
            bit legal;
            legal = (k == 0) ? (nums[j] == 0) : (k == 1) ? (nums[j] >= 1 && nums[j] <= 32)
                                                         : (nums[j] >= 1 && nums[j] <= 2048);
            reg_write(R_INUM, nums[j]);
            run_cmd(32'h1 << k);
            check("R5 legacy pulse count", pl, (legal && k == 0) ? 1 : 0);
            check("R5 MSI pulse count",    pm, (legal && k == 1) ? 1 : 0);
            check("R6 MSI-X pulse count",  px, (legal && k == 2) ? 1 : 0);
            if (legal) check("R5 vector", 32'(last_vec), nums[j] & 32'hFFF);
            reg_read(R_STAT, d); check("R6 status bit6", d, legal ? 32'h40 : 32'h0);
         end
      end

      // R7 R11 read sweep, correct and wrong checksum
      reg_write(R_SRC, SRC);
      for (int n = 0; n <= 4; n++) begin
         for (int t = 0; t <= 4; t++) begin
            for (int good = 0; good < 2; good++) begin
               x = 0;
               for (int i = 0; i < n; i++) begin mem[16+i] = pat(i, n + t); x ^= pat(i, n + t); end
               reg_write(R_ITYPE, ityp(t)); reg_write(R_INUM, inum(t)); reg_write(R_LEN, 32'(n));
               reg_write(R_CHK, good ? x : ~x);
               a0 = n_acc;
               run_cmd(32'h08);
               check("R7 access count", 32'(n_acc - a0), 32'(n));
               reg_read(R_STAT, d);
               check("R7 read status", d, (good ? 32'h1 : 32'h2) | ((t <= 2) ? 32'h40 : 32'h0));
               check_irq("R11 read completion", t);
            end
         end
      end

      // R8 write sweep
      for (int n = 0; n <= 5; n++) begin
         for (int i = 0; i < 8; i++) mem[32+i] = 32'hBEEF_0000 + 32'(i);
         reg_write(R_DST, DST); reg_write(R_LEN, 32'(n)); reg_write(R_CHK, 32'hFFFF_FFFF);
         reg_write(R_ITYPE, ityp(n % 5)); reg_write(R_INUM, inum(n % 5));
         run_cmd(32'h10);
         x = 0;
         for (int i = 0; i < n; i++) begin check("R8 written word", mem[32+i], 32'(i)); x ^= 32'(i); end
         check("R8 word past end untouched", mem[32+n], 32'hBEEF_0000 + 32'(n));
         reg_read(R_CHK, d); check("R8 checksum register", d, x);
         reg_read(R_STAT, d); check("R8 write status", d, 32'h4 | ((n % 5 <= 2) ? 32'h40 : 32'h0));
         check_irq("R11 write completion", n % 5);
      end

      // R9 copy sweep
      reg_write(R_ITYPE, 2); reg_write(R_INUM, 2048);
      for (int n = 1; n <= 5; n++) begin
         for (int i = 0; i < 8; i++) begin mem[16+i] = pat(i, 40 + n); mem[32+i] = 32'hC0DE_0000; end
         reg_write(R_LEN, 32'(n));
         run_cmd(32'h20);
         for (int i = 0; i < n; i++) check("R9 copied word", mem[32+i], pat(i, 40 + n));
         check("R9 word past end untouched", mem[32+n], 32'hC0DE_0000);
         check("R9 source intact", mem[16], pat(0, 40 + n));
         reg_read(R_STAT, d); check("R9 copy status", d, 32'h10 | 32'h40);
         check("R11 copy completion MSI-X", px, 1);
      end

      // R10 invalid addresses, no access
      reg_write(R_ITYPE, 3); reg_write(R_LEN, 2);
      for (int v = 0; v < 2; v++) begin
         logic [31:0] bad = v ? 32'h42 : 32'h0;
         reg_write(R_SRC, bad); reg_write(R_DST, DST); a0 = n_acc;
         run_cmd(32'h08); reg_read(R_STAT, d); check("R10 bad source read", d, 32'h82);
         check("R10 no access", 32'(n_acc - a0), 0);
         run_cmd(32'h20); reg_read(R_STAT, d); check("R10 bad source copy", d, 32'hA0);
         reg_write(R_SRC, SRC); reg_write(R_DST, bad | (v ? 32'h81 : 32'h0));
         run_cmd(32'h10); reg_read(R_STAT, d); check("R10 bad dest write", d, 32'h108);
         run_cmd(32'h20); reg_read(R_STAT, d); check("R10 bad dest copy", d, 32'h120);
         reg_write(R_SRC, bad);
         run_cmd(32'h20); reg_read(R_STAT, d); check("R10 both bad copy", d, 32'h1A0);
         check("R10 no access at all", 32'(n_acc - a0), 0);
      end

      // R3 priority: read beats write, MSI beats read, legacy beats all
      reg_write(R_SRC, SRC); reg_write(R_DST, DST); reg_write(R_LEN, 3);
      reg_write(R_ITYPE, 3);
      x = mem[16] ^ mem[17] ^ mem[18];
      reg_write(R_CHK, x);
      for (int i = 0; i < 4; i++) mem[32+i] = 32'h5A5A_0000;
      run_cmd(32'h18); reg_read(R_STAT, d); check("R3 read wins over write", d, 32'h1);
      check("R3 no write happened", mem[32], 32'h5A5A_0000);
      reg_write(R_INUM, 9); a0 = n_acc;
      run_cmd(32'h0A); reg_read(R_STAT, d); check("R3 MSI wins over read", d, 32'h40);
      check("R3 MSI pulse", pm, 1); check("R3 no access", 32'(n_acc - a0), 0);
      reg_write(R_INUM, 0);
      run_cmd(32'h3F); check("R3 legacy wins", pl, 1); check("R3 no MSI", pm + px, 0);

      // R4 busy rewrite ignored, R2 status cleared on start
      reg_write(R_CHK, x); reg_write(R_ITYPE, 1); reg_write(R_INUM, 3);
      reg_write(R_LEN, 0); run_cmd(32'h08);
      reg_read(R_STAT, d); check("R2 nonzero status before start", d, 32'h42);
      reg_write(R_LEN, 3);
      reg_write(R_CMD, 32'h08);
      reg_read(R_STAT, d); check("R2 status cleared at start", d, 0);
      reg_read(R_CMD, d);  check("R2 command reads back while busy", d, 32'h08);
      reg_write(R_CMD, 32'h10);
      reg_read(R_CMD, d);  check("R4 busy rewrite ignored", d, 32'h08);
      wait_done();
      reg_read(R_STAT, d); check("R4 only first command ran", d, 32'h41);
      check("R4 no write from ignored command", mem[32], 32'h5A5A_0000);
      check("R4 single completion pulse", pm, 1);
      reg_read(R_CMD, d); check("R2 command cleared", d, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule